// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This block is a compact processor core that keeps all operands on a hardware evaluation stack instead of in a register file. It fetches 24-bit instructions from a small internal instruction memory and executes one instruction per clock. Only push and pop carry a memory address. Arithmetic, shift, the indirect accesses and the conditional jump take their operands from the stack alone.

After reset the core sits idle while a loader fills the instruction memory through a write port. A one-cycle pulse on `start_i` begins execution at address 0. The core runs until it reaches a halt opcode or hits a stack fault. It then stays halted until the next reset. A debug port reads the data memory at any time, so the results of a program can be collected.

Top module: `stk_core`

## Requirements
- R1: After reset, `halted_o`, `ovf_o` and `unf_o` are low, and no instruction executes until `start_i` is pulsed. A single pulse starts fetching at instruction address 0.
- R2: An instruction holds the opcode in bits [23:16] and the operand in bits [15:0]. The opcodes are halt=0x00, push-immediate=0x01, push=0x02, pop=0x03, add=0x04, sub=0x05, shift-left=0x06, indirect push=0x07, indirect pop=0x08 and jump-if-greater=0x09. Opcodes that take no address ignore the operand.
- R3: Push-immediate places the operand on the stack. Push places data word `mem[operand]` on the stack. Pop removes the top entry and writes it to `mem[operand]`. Data addresses use the low 6 bits of the operand.
- R4: Add and sub each remove the top two entries and push one 16-bit result. Add pushes top + next. Sub pushes top − next, so the most recently pushed operand is the minuend.
- R5: Shift-left removes the count from the top and pushes the entry below it shifted left by that count. Counts of 16 or more give 0.
- R6: Indirect push replaces the top entry A with `mem[A]`. Indirect pop writes the entry below the top to `mem[top]` and removes both entries.
- R7: Jump-if-greater removes three entries. If the second entry is greater than the third (unsigned), execution continues at the low 6 bits of the top entry. Otherwise it continues at the next instruction.
- R8: The stack holds 16 entries. A push onto a full stack does not execute, sets the sticky `ovf_o` and halts the core.
- R9: An instruction that needs more entries than the stack holds does not execute and writes nothing. It sets the sticky `unf_o` and halts the core.
- R10: The halt opcode stops fetching and raises `halted_o` until reset. Later `start_i` pulses are ignored.
- R11: Opcodes outside the defined set act as no-operations.
- R12: `dbg_rdata_o` shows data word `mem[dbg_addr_i]` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin execution at address 0 |
| imem_we_i | input | 1 | Instruction memory write enable |
| imem_addr_i | input | 6 | Instruction memory write address |
| imem_wdata_i | input | 24 | Instruction word to write |
| dbg_addr_i | input | 6 | Data memory debug read address |
| dbg_rdata_o | output | 16 | Data memory debug read data |
| halted_o | output | 1 | Core has stopped |
| ovf_o | output | 1 | Sticky stack overflow flag |
| unf_o | output | 1 | Sticky stack underflow flag |

## Verification
The stack pointer and the stack entries are visible only through memory contents and the fault flags. A stack pointer that is off by one therefore shows up as a wrong word, found by a debug read after the program stops, or as a fault flag raised too early or too late. Each check ends its program by popping the value under test to a known address. Some programs also add a trailing operation that must underflow, which exposes extra or missing pops within a few instructions of the fault. An error in the jump comparison or the jump target changes which of two marker values reaches memory. Such an error can also leave the core unhalted, which the bounded wait reports.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int INSW = 24;
  localparam int ARGW = 16;

  typedef enum logic [7:0] {
    OP_HALT  = 8'h00,
    OP_PUSHI = 8'h01,
    OP_PUSH  = 8'h02,
    OP_POP   = 8'h03,
    OP_ADD   = 8'h04,
    OP_SUB   = 8'h05,
    OP_SHL   = 8'h06,
    OP_PUSHX = 8'h07,
    OP_POPX  = 8'h08,
    OP_JGT   = 8'h09
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HALT} st_e;
endpackage

// File: rtl/stk_stack.sv
module stk_stack #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     pop_i,
  input  logic           push_i,
  input  logic [DW-1:0]  push_data_i,
  output logic [DW-1:0]  top0_o,
  output logic [DW-1:0]  top1_o,
  output logic [DW-1:0]  top2_o,
  output logic [SPW-1:0] sp_o
);
  logic [DW-1:0]  mem_q [DEPTH];
  logic [SPW-1:0] sp_q;
  logic [SPW-1:0] wr_idx;
  logic [DW-1:0]  tops [3];

  for (genvar k = 0; k < 3; k++) begin : g_top
    logic [SPW-1:0] idx;
    assign idx     = sp_q - SPW'(k + 1);
    assign tops[k] = mem_q[idx[IW-1:0]];
  end

  assign top0_o = tops[0];
  assign top1_o = tops[1];
  assign top2_o = tops[2];
  assign sp_o   = sp_q;
  assign wr_idx = sp_q - SPW'(pop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      sp_q <= sp_q - SPW'(pop_i) + SPW'(push_i);
      if (push_i) mem_q[wr_idx[IW-1:0]] <= push_data_i;
    end
  end
endmodule

// File: rtl/stk_dmem.sv
module stk_dmem #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic [AW-1:0] dbg_addr_i,
  output logic [DW-1:0] dbg_rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o     = mem_q[raddr_i];
  assign dbg_rdata_o = mem_q[dbg_addr_i];
endmodule

// File: rtl/stk_imem.sv
module stk_imem #(
  parameter int W     = 24,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int DW         = 16,
  parameter int STK_DEPTH  = 16,
  parameter int DMEM_DEPTH = 64,
  parameter int IMEM_DEPTH = 64,
  localparam int DAW = $clog2(DMEM_DEPTH),
  localparam int IAW = $clog2(IMEM_DEPTH),
  localparam int SPW = $clog2(STK_DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            imem_we_i,
  input  logic [IAW-1:0]  imem_addr_i,
  input  logic [INSW-1:0] imem_wdata_i,
  input  logic [DAW-1:0]  dbg_addr_i,
  output logic [DW-1:0]   dbg_rdata_o,
  output logic            halted_o,
  output logic            ovf_o,
  output logic            unf_o
);
  st_e             st_q;
  logic [IAW-1:0]  pc_q, pc_nx;
  logic            ovf_q, unf_q;
  logic [INSW-1:0] instr;
  logic [7:0]      opc;
  logic [ARGW-1:0] arg;
  logic [DW-1:0]   t0, t1, t2;
  logic [SPW-1:0]  sp;
  logic [1:0]      pop_n, stk_pop;
  logic            push, stk_push;
  logic [DW-1:0]   push_d;
  logic            dm_we, dm_we_raw;
  logic [DAW-1:0]  dm_waddr, dm_raddr;
  logic [DW-1:0]   dm_wdata, dm_rdata;
  logic            is_halt, ovf_hit, unf_hit, run, exec;

  assign opc = instr[23:16];
  assign arg = instr[15:0];

  always_comb begin
    pop_n     = 2'd0;
    push      = 1'b0;
    push_d    = '0;
    dm_we_raw = 1'b0;
    dm_waddr  = arg[DAW-1:0];
    dm_wdata  = t0;
    dm_raddr  = arg[DAW-1:0];
    pc_nx     = pc_q + IAW'(1);
    is_halt   = 1'b0;
    case (opc)
      OP_HALT:  is_halt = 1'b1;
      OP_PUSHI: begin push = 1'b1; push_d = DW'(arg); end
      OP_PUSH:  begin push = 1'b1; push_d = dm_rdata; end
      OP_POP:   begin pop_n = 2'd1; dm_we_raw = 1'b1; end
      OP_ADD:   begin pop_n = 2'd2; push = 1'b1; push_d = t0 + t1; end
      OP_SUB:   begin pop_n = 2'd2; push = 1'b1; push_d = t0 - t1; end
      OP_SHL:   begin pop_n = 2'd2; push = 1'b1; push_d = t1 << t0; end
      OP_PUSHX: begin
        pop_n = 2'd1; push = 1'b1;
        dm_raddr = t0[DAW-1:0]; push_d = dm_rdata;
      end
      OP_POPX:  begin
        pop_n = 2'd2; dm_we_raw = 1'b1;
        dm_waddr = t0[DAW-1:0]; dm_wdata = t1;
      end
      OP_JGT:   begin
        pop_n = 2'd3;
        if (t1 > t2) pc_nx = t0[IAW-1:0];
      end
      default: ;
    endcase
  end

  assign run      = (st_q == ST_RUN);
  assign ovf_hit  = push && (pop_n == 2'd0) && (sp == SPW'(STK_DEPTH));
  assign unf_hit  = (sp < SPW'(pop_n));
  assign exec     = run && !is_halt && !ovf_hit && !unf_hit;
  assign stk_pop  = exec ? pop_n : 2'd0;
  assign stk_push = exec && push;
  assign dm_we    = exec && dm_we_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      pc_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin st_q <= ST_RUN; pc_q <= '0; end
        ST_RUN: begin
          if (ovf_hit) begin ovf_q <= 1'b1; st_q <= ST_HALT; end
          else if (unf_hit) begin unf_q <= 1'b1; st_q <= ST_HALT; end
          else if (is_halt) st_q <= ST_HALT;
          else pc_q <= pc_nx;
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end

  assign halted_o = (st_q == ST_HALT);
  assign ovf_o    = ovf_q;
  assign unf_o    = unf_q;

  stk_imem #(.W(INSW), .DEPTH(IMEM_DEPTH)) u_imem (
    .clk_i, .we_i(imem_we_i), .waddr_i(imem_addr_i), .wdata_i(imem_wdata_i),
    .raddr_i(pc_q), .rdata_o(instr)
  );

  stk_dmem #(.DW(DW), .DEPTH(DMEM_DEPTH)) u_dmem (
    .clk_i, .we_i(dm_we), .waddr_i(dm_waddr), .wdata_i(dm_wdata),
    .raddr_i(dm_raddr), .rdata_o(dm_rdata),
    .dbg_addr_i, .dbg_rdata_o
  );

  stk_stack #(.DW(DW), .DEPTH(STK_DEPTH)) u_stack (
    .clk_i, .rst_ni, .pop_i(stk_pop), .push_i(stk_push), .push_data_i(push_d),
    .top0_o(t0), .top1_o(t1), .top2_o(t2), .sp_o(sp)
  );
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
  parameter int STK_DEPTH = 16,
  parameter int SPW       = 5
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           halted_o,
  input logic           ovf_o,
  input logic           unf_o,
  input logic [SPW-1:0] sp_i
);
  p_halt_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);
  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  p_unf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> unf_o);
  p_fault_halts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o || unf_o) |-> halted_o);
  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_i <= SPW'(STK_DEPTH));
  p_halt_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> $stable(sp_i));
  p_one_fault_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o));
endmodule

bind stk_core stk_core_chk #(.STK_DEPTH(STK_DEPTH), .SPW(SPW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .halted_o(halted_o),
  .ovf_o(ovf_o), .unf_o(unf_o), .sp_i(sp)
);

// File: tb/stk_core_tb.sv
module stk_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        imem_we = 1'b0;
  logic [5:0]  imem_addr = '0;
  logic [23:0] imem_wdata = '0;
  logic [5:0]  dbg_addr = '0;
  logic [15:0] dbg_rdata;
  logic        halted, ovf, unf;

  int n_chk = 0;
  int n_bad = 0;
  logic [23:0] prog [64];
  int plen;

  always #5 clk = ~clk;

  stk_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .imem_we_i(imem_we), .imem_addr_i(imem_addr), .imem_wdata_i(imem_wdata),
    .dbg_addr_i(dbg_addr), .dbg_rdata_o(dbg_rdata),
    .halted_o(halted), .ovf_o(ovf), .unf_o(unf)
  );

  localparam logic [7:0] HLT = 8'h00, PSI = 8'h01, PSH = 8'h02, POP = 8'h03,
    ADD = 8'h04, SUB = 8'h05, SHL = 8'h06, PSX = 8'h07, POX = 8'h08, JGT = 8'h09;

  function automatic logic [15:0] model_arith(logic [7:0] op, logic [15:0] top, logic [15:0] nxt);
    case (op)
      ADD: return top + nxt;
      SUB: return top - nxt;
      default: return (top >= 16) ? 16'h0 : (nxt << top[3:0]);
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clr(); plen = 0; endtask
  task automatic emit(input logic [7:0] op, input logic [15:0] a);
    prog[plen] = {op, a}; plen++;
  endtask

  task automatic load();
    for (int i = 0; i < plen; i++) begin
      @(negedge clk); imem_we = 1'b1; imem_addr = 6'(i); imem_wdata = prog[i];
    end
    @(negedge clk); imem_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input string tag);
    int n;
    load();
    do_reset();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!halted && n < 400) begin @(negedge clk); n++; end
    chk(halted, {tag, " halt reached"}, 32'(halted), 1);
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    dbg_addr = a; #1; d = dbg_rdata;
  endtask

  logic [15:0] v;

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: idle until start
    clr(); emit(HLT, 16'h0); load(); do_reset();
    repeat (10) @(negedge clk);
    chk(!halted && !ovf && !unf, "R1 idle after reset", {29'b0, halted, ovf, unf}, 0);
    start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    chk(halted, "R1 start runs address 0", 32'(halted), 1);
    // R10: start ignored after halt
    start = 1'b1; @(negedge clk); start = 1'b0; repeat (5) @(negedge clk);
    chk(halted, "R10 halt sticky", 32'(halted), 1);

    // R3: push/pop direct with address wrap
    clr(); emit(PSI, 16'd1234); emit(POP, 16'd94); emit(PSH, 16'd30);
    emit(PSI, 16'd1); emit(ADD, 16'hFFFF); emit(POP, 16'd31); emit(HLT, 0);
    run("R3");
    rd(6'd30, v); chk(v == 16'd1234, "R3 pop with wrapped address", v, 1234);
    rd(6'd31, v); chk(v == 16'd1235, "R3 push direct", v, 1235);

    // R2 R4 R5: random arithmetic, garbage operand on zero-address ops
    for (int it = 0; it < 30; it++) begin
      logic [7:0] op;
      logic [15:0] a, b, e;
      logic [5:0] ad;
      op = 8'(ADD + ($urandom % 3));
      b = 16'($urandom);
      a = (op == SHL) ? 16'($urandom % 20) : 16'($urandom);
      ad = 6'(32 + ($urandom % 16));
      e = model_arith(op, a, b);
      clr(); emit(PSI, b); emit(PSI, a); emit(op, 16'($urandom)); emit(POP, 16'(ad)); emit(HLT, 16'($urandom));
      run("R4");
      rd(ad, v);
      chk(v == e, (op == SHL) ? "R5 shift-left result" : "R4 R2 arith result", v, e);
    end
    // R5: count exactly 16 gives 0
    clr(); emit(PSI, 16'hFFFF); emit(PSI, 16'd16); emit(SHL, 0); emit(POP, 16'd33); emit(HLT, 0);
    run("R5");
    rd(6'd33, v); chk(v == 16'h0, "R5 shift by 16", v, 0);

    // R6: indirect pop then indirect push
    clr(); emit(PSI, 16'd77); emit(PSI, 16'd9); emit(POX, 0); emit(PSI, 16'd9);
    emit(PSX, 0); emit(POP, 16'd12); emit(ADD, 0); emit(HLT, 0);
    run("R6");
    rd(6'd9, v);  chk(v == 16'd77, "R6 indirect pop", v, 77);
    rd(6'd12, v); chk(v == 16'd77, "R6 indirect push", v, 77);
    chk(unf, "R6 indirect ops leave stack empty", 32'(unf), 1);

    // R7: jump taken, then consumed-three check via underflow
    for (int tk = 0; tk < 3; tk++) begin
      logic [15:0] sec, thd, e;
      sec = (tk == 0) ? 16'd7 : 16'd3;
      thd = (tk == 1) ? 16'd7 : 16'd3;
      e = (sec > thd) ? 16'd222 : 16'd111;
      clr(); emit(PSI, thd); emit(PSI, sec); emit(PSI, 16'd8); emit(JGT, 0);
      emit(PSI, 16'd111); emit(POP, 16'd1); emit(ADD, 0); emit(HLT, 0);
      emit(PSI, 16'd222); emit(POP, 16'd1); emit(ADD, 0); emit(HLT, 0);
      run("R7");
      rd(6'd1, v); chk(v == e, "R7 jump path", v, e);
      chk(unf && !ovf, "R7 three entries removed", {30'b0, ovf, unf}, 1);
    end

    // R8: exactly 16 fit, 17th overflows
    clr();
    for (int i = 0; i < 16; i++) emit(PSI, 16'(100 + i));
    emit(POP, 16'd41); emit(PSI, 16'd1); emit(PSI, 16'd2); emit(POP, 16'd42); emit(HLT, 0);
    prog[19] = {POP, 16'd42};
    run("R8");
    rd(6'd41, v); chk(v == 16'd115, "R8 sixteenth entry kept", v, 115);
    chk(ovf && !unf, "R8 overflow flag", {30'b0, ovf, unf}, 2);

    // R9: underflow writes nothing
    clr(); emit(PSI, 16'd4321); emit(POP, 16'd50); emit(HLT, 0);
    run("R9");
    clr(); emit(PSI, 16'd9); emit(ADD, 0); emit(POP, 16'd50); emit(HLT, 0);
    run("R9");
    rd(6'd50, v); chk(v == 16'd4321, "R9 no write after underflow", v, 4321);
    chk(unf && !ovf, "R9 underflow flag", {30'b0, ovf, unf}, 1);

    // R11: undefined opcode is a no-op
    clr(); emit(PSI, 16'd5); emit(8'hEE, 16'h1234); emit(POP, 16'd51); emit(HLT, 0);
    run("R11");
    rd(6'd51, v); chk(v == 16'd5 && !unf && !ovf, "R11 undefined opcode", v, 5);

    // R12: debug read follows address same cycle
    rd(6'd9, v); chk(v == 16'd77, "R12 debug read", v, 77);
    rd(6'd30, v); chk(v == 16'd1234, "R12 debug read", v, 1234);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule